// File: doc/BRIEF.md
# Root-Port Interrupt and Error Message Queue

This block sits behind the receive side of a PCI Express root port and buffers the interrupt-related messages that arrive from downstream: legacy INTx assertions, MSI memory writes and error messages. INTx and MSI arrivals share a single interrupt queue, and a flag in each entry tells them apart. Error messages go into a separate queue. The oldest entry of each queue is shown through read-only head registers. Software reads the head and then removes it by writing all ones to the head's first register. Reading alone never removes anything.

Three level outputs feed the interrupt decode logic. One is high while the interrupt head is an INTx entry, one while it is an MSI entry, and one while the error queue holds anything. An MSI write is accepted only when its 64-bit address equals the MSI target base. Software programs that base as two 32-bit halves. Each queue has a fixed depth. When a queue is full, new arrivals are discarded and a sticky overflow flag is set.

Top module: `rpq_msg_queue`

## Requirements
- R1: After reset, every register index (0 to 4) reads zero and `intx_level`, `msi_level` and `err_level` are low.
- R2: An INTx arrival (`msg_kind`=0) with line `msg_line` (A..D encoded 0..3) is queued. When it is at the head, index 2 reads bit 31=1, bit 30=0, bits 28:27=line, index 3 reads zero, and `intx_level` is high from the cycle after the arrival.
- R3: An MSI arrival (`msg_kind`=1) whose `msg_addr` equals {index 1, index 0} is queued. When it is at the head, index 2 reads bit 31=1 and bit 30=1, index 3 bits 15:0 read `msg_data`, and `msi_level` is high.
- R4: An MSI arrival whose address differs from the base in either half is discarded.
- R5: An error arrival (`msg_kind`=2) is queued. When it is at the head, index 4 reads bit 18=1 with bits 15:0 equal to `msg_reqid`, and `err_level` is high from the cycle after the arrival.
- R6: Writing 0xFFFFFFFF to index 2 pops the interrupt head, and writing 0xFFFFFFFF to index 4 pops the error head. Reads, any other write value, and writes to index 3 leave the queues unchanged.
- R7: INTx and MSI entries leave the shared queue in arrival order. `intx_level` and `msi_level` are never high together.
- R8: With a queue empty, its valid bit and entry fields read zero. Index 2 bits 31:27 and index 3 read zero; index 4 bits 18 and 15:0 read zero.
- R9: A pop of an empty queue has no effect. A later arrival becomes the head and is the only entry.
- R10: Each queue holds DEPTH (8) entries. An arrival at a full queue is dropped and sets a sticky overflow bit: index 2 bit 26 for the interrupt queue, index 4 bit 17 for the error queue. The bit stays set until reset.
- R11: Index 0 (low half) and index 1 (high half) of the MSI base are written by `reg_we` and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Message arrival strobe, one per cycle |
| msg_kind | input | 2 | 0 INTx, 1 MSI, 2 error |
| msg_line | input | 2 | INTx line, A..D as 0..3 |
| msg_data | input | 16 | MSI message data |
| msg_addr | input | 64 | MSI write address |
| msg_reqid | input | 16 | Error message requester ID |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| intx_level | output | 1 | Interrupt head is an INTx entry |
| msi_level | output | 1 | Interrupt head is an MSI entry |
| err_level | output | 1 | Error queue not empty |

## Verification
The bench goes after the points where a queue with a software-driven pop tends to fail. These are a read that quietly pops (entries go missing), a write value other than all ones that pops, a pop on an empty queue that corrupts the count (phantom or lost entries afterwards), and an MSI address compare that checks only one half (stray entries appear). It fills each queue past its depth. A wrong full test would overwrite the oldest entries or return them out of order, and an overflow flag that is not sticky would read zero once the queue drains. It also interleaves INTx and MSI arrivals. A design that split them or mislabelled them would return the wrong type flag or level at the head.

// File: rtl/rpq_pkg.sv
package rpq_pkg;

    localparam int DATA_W = 16;
    localparam int ID_W   = 16;
    localparam int LINE_W = 2;

    localparam logic [1:0] KIND_INTX = 2'd0;
    localparam logic [1:0] KIND_MSI  = 2'd1;
    localparam logic [1:0] KIND_ERR  = 2'd2;

    localparam logic [2:0] IDX_BASE_LO   = 3'd0;
    localparam logic [2:0] IDX_BASE_HI   = 3'd1;
    localparam logic [2:0] IDX_IRQ_FLAGS = 3'd2;
    localparam logic [2:0] IDX_IRQ_DATA  = 3'd3;
    localparam logic [2:0] IDX_ERR_HEAD  = 3'd4;

    localparam logic [31:0] POP_CODE = 32'hFFFF_FFFF;

    typedef struct packed {
        logic              is_msi;
        logic [LINE_W-1:0] line;
        logic [DATA_W-1:0] data;
    } irq_entry_t;

    localparam int IRQ_W = $bits(irq_entry_t);

endpackage

// File: rtl/rpq_fifo.sv
module rpq_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         head_valid,
    output logic [W-1:0] head_data,
    output logic         ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wr;
        logic [AW-1:0]           rd;
        logic [CW-1:0]           cnt;
        logic                    ovf;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     full, empty, do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        full    = (st_q.cnt == CW'(DEPTH));
        empty   = (st_q.cnt == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;

        if (push && full) begin
            st_d.ovf = 1'b1;
        end
        if (do_push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_valid = !empty;
    assign head_data  = empty ? '0 : st_q.mem[st_q.rd];
    assign ovf        = st_q.ovf;

endmodule

// File: rtl/rpq_classify.sv
module rpq_classify
    import rpq_pkg::*;
(
    input  logic              msg_valid,
    input  logic [1:0]        msg_kind,
    input  logic [LINE_W-1:0] msg_line,
    input  logic [DATA_W-1:0] msg_data,
    input  logic [63:0]       msg_addr,
    input  logic [ID_W-1:0]   msg_reqid,
    input  logic [31:0]       base_lo,
    input  logic [31:0]       base_hi,
    output logic              irq_push,
    output irq_entry_t        irq_entry,
    output logic              err_push,
    output logic [ID_W-1:0]   err_id
);
    logic addr_hit;

    always_comb begin
        addr_hit  = (msg_addr == {base_hi, base_lo});
        irq_push  = 1'b0;
        irq_entry = '0;
        err_push  = 1'b0;
        err_id    = msg_reqid;
        if (msg_valid) begin
            case (msg_kind)
                KIND_INTX: begin
                    irq_push       = 1'b1;
                    irq_entry.line = msg_line;
                end
                KIND_MSI: begin
                    irq_push         = addr_hit;
                    irq_entry.is_msi = 1'b1;
                    irq_entry.data   = msg_data;
                end
                KIND_ERR: begin
                    err_push = 1'b1;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/rpq_csr.sv
module rpq_csr
    import rpq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [2:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    input  logic            irq_head_valid,
    input  irq_entry_t      irq_head,
    input  logic            irq_ovf,
    input  logic            err_head_valid,
    input  logic [ID_W-1:0] err_head,
    input  logic            err_ovf,
    output logic [31:0]     reg_rdata,
    output logic [31:0]     base_lo,
    output logic [31:0]     base_hi,
    output logic            irq_pop,
    output logic            err_pop
);
    typedef struct packed {
        logic [31:0] base_lo;
        logic [31:0] base_hi;
    } csr_st_t;

    csr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reg_we && reg_addr == IDX_BASE_LO) st_d.base_lo = reg_wdata;
        if (reg_we && reg_addr == IDX_BASE_HI) st_d.base_hi = reg_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_pop = reg_we && (reg_addr == IDX_IRQ_FLAGS) && (reg_wdata == POP_CODE);
    assign err_pop = reg_we && (reg_addr == IDX_ERR_HEAD) && (reg_wdata == POP_CODE);
    assign base_lo = st_q.base_lo;
    assign base_hi = st_q.base_hi;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            IDX_BASE_LO: reg_rdata = st_q.base_lo;
            IDX_BASE_HI: reg_rdata = st_q.base_hi;
            IDX_IRQ_FLAGS: begin
                reg_rdata[31]    = irq_head_valid;
                reg_rdata[30]    = irq_head.is_msi;
                reg_rdata[28:27] = irq_head.line;
                reg_rdata[26]    = irq_ovf;
            end
            IDX_IRQ_DATA: reg_rdata[DATA_W-1:0] = irq_head.data;
            IDX_ERR_HEAD: begin
                reg_rdata[18]         = err_head_valid;
                reg_rdata[17]         = err_ovf;
                reg_rdata[ID_W-1:0]   = err_head;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rpq_msg_queue.sv
module rpq_msg_queue
    import rpq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        msg_valid,
    input  logic [1:0]  msg_kind,
    input  logic [1:0]  msg_line,
    input  logic [15:0] msg_data,
    input  logic [63:0] msg_addr,
    input  logic [15:0] msg_reqid,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        intx_level,
    output logic        msi_level,
    output logic        err_level
);
    logic              irq_push, err_push, irq_pop, err_pop;
    irq_entry_t        irq_entry, irq_head;
    logic [IRQ_W-1:0]  irq_head_raw;
    logic [ID_W-1:0]   err_id, err_head;
    logic              irq_valid, err_valid, irq_ovf, err_ovf;
    logic [31:0]       base_lo, base_hi;

    rpq_classify u_classify (
        .msg_valid (msg_valid),
        .msg_kind  (msg_kind),
        .msg_line  (msg_line),
        .msg_data  (msg_data),
        .msg_addr  (msg_addr),
        .msg_reqid (msg_reqid),
        .base_lo   (base_lo),
        .base_hi   (base_hi),
        .irq_push  (irq_push),
        .irq_entry (irq_entry),
        .err_push  (err_push),
        .err_id    (err_id)
    );

    rpq_fifo #(.W(IRQ_W), .DEPTH(DEPTH)) u_irq_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (irq_push),
        .push_data  (irq_entry),
        .pop        (irq_pop),
        .head_valid (irq_valid),
        .head_data  (irq_head_raw),
        .ovf        (irq_ovf)
    );

    rpq_fifo #(.W(ID_W), .DEPTH(DEPTH)) u_err_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (err_push),
        .push_data  (err_id),
        .pop        (err_pop),
        .head_valid (err_valid),
        .head_data  (err_head),
        .ovf        (err_ovf)
    );

    assign irq_head = irq_entry_t'(irq_head_raw);

    rpq_csr u_csr (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_we         (reg_we),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .irq_head_valid (irq_valid),
        .irq_head       (irq_head),
        .irq_ovf        (irq_ovf),
        .err_head_valid (err_valid),
        .err_head       (err_head),
        .err_ovf        (err_ovf),
        .reg_rdata      (reg_rdata),
        .base_lo        (base_lo),
        .base_hi        (base_hi),
        .irq_pop        (irq_pop),
        .err_pop        (err_pop)
    );

    assign intx_level = irq_valid && !irq_head.is_msi;
    assign msi_level  = irq_valid && irq_head.is_msi;
    assign err_level  = err_valid;

endmodule

// File: rtl/rpq_msg_queue_chk.sv
module rpq_msg_queue_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        msg_valid,
    input logic [1:0]  msg_kind,
    input logic        reg_we,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        intx_level,
    input logic        msi_level,
    input logic        err_level,
    input logic        irq_ovf,
    input logic        err_ovf
);
    logic irq_pop_wr, err_pop_wr;
    assign irq_pop_wr = reg_we && reg_addr == 3'd2 && reg_wdata == 32'hFFFF_FFFF;
    assign err_pop_wr = reg_we && reg_addr == 3'd4 && reg_wdata == 32'hFFFF_FFFF;

    assert_levels_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(intx_level && msi_level));

    assert_intx_rise_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intx_level) |-> ($past(msg_valid && msg_kind == 2'd0) || $past(irq_pop_wr)));

    assert_err_rise_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_level) |-> $past(msg_valid && msg_kind == 2'd2));

    assert_err_fall_needs_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_level) |-> $past(err_pop_wr));

    assert_empty_pop_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_level && !(msg_valid && msg_kind == 2'd2)) |=> !err_level);

    assert_empty_err_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd4 && !err_level) |-> ((reg_rdata & 32'hFFFD_FFFF) == 32'h0));

    assert_irq_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovf |=> irq_ovf);

    assert_err_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_ovf |=> err_ovf);

endmodule

bind rpq_msg_queue rpq_msg_queue_chk u_chk (.*);

// File: tb/tb_rpq_msg_queue.sv
module tb_rpq_msg_queue;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        msg_valid;
    logic [1:0]  msg_kind;
    logic [1:0]  msg_line;
    logic [15:0] msg_data;
    logic [63:0] msg_addr;
    logic [15:0] msg_reqid;
    logic        reg_we;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        intx_level, msi_level, err_level;

    always #10 clk = ~clk;

    rpq_msg_queue dut (.*);

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [31:0] exp_irq_a[$];
    logic [31:0] exp_irq_b[$];
    logic [31:0] exp_err[$];
    bit irq_ovf_e = 0, err_ovf_e = 0;
    logic [31:0] base_lo_e = '0, base_hi_e = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
        if (a == 3'd0) base_lo_e = d;
        if (a == 3'd1) base_hi_e = d;
    endtask

    task automatic send(input logic [1:0] k, input logic [1:0] ln, input logic [15:0] dt,
                        input logic [63:0] ad, input logic [15:0] id);
        @(negedge clk);
        msg_valid = 1'b1; msg_kind = k; msg_line = ln; msg_data = dt;
        msg_addr = ad; msg_reqid = id;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    // Driver tasks: stimulate and record the expected queue content
    task automatic send_intx(input logic [1:0] ln);
        send(2'd0, ln, 16'h0, 64'h0, 16'h0);
        if (exp_irq_a.size() < 8) begin
            exp_irq_a.push_back(32'h8000_0000 | (32'(ln) << 27));
            exp_irq_b.push_back(32'h0);
        end else irq_ovf_e = 1;
    endtask

    task automatic send_msi(input logic [15:0] dt, input logic [63:0] ad);
        send(2'd1, 2'd0, dt, ad, 16'h0);
        if (ad == {base_hi_e, base_lo_e}) begin
            if (exp_irq_a.size() < 8) begin
                exp_irq_a.push_back(32'hC000_0000);
                exp_irq_b.push_back({16'h0, dt});
            end else irq_ovf_e = 1;
        end
    endtask

    task automatic send_err(input logic [15:0] id);
        send(2'd2, 2'd0, 16'h0, 64'h0, id);
        if (exp_err.size() < 8) exp_err.push_back(32'h0004_0000 | {16'h0, id});
        else err_ovf_e = 1;
    endtask

    // Monitor tasks: compare heads with the scoreboard, then pop
    task automatic drain_irq(input string req);
        logic [31:0] v;
        while (exp_irq_a.size() > 0) begin
            rd(3'd2, v);
            chk({req, " irq flags"}, v, exp_irq_a[0] | (32'(irq_ovf_e) << 26));
            chk({req, " levels R7"}, {30'h0, intx_level, msi_level},
                exp_irq_a[0][30] ? 32'h1 : 32'h2);
            rd(3'd3, v);
            chk({req, " irq data"}, v, exp_irq_b[0]);
            wr(3'd2, 32'hFFFF_FFFF);
            void'(exp_irq_a.pop_front());
            void'(exp_irq_b.pop_front());
        end
        rd(3'd2, v);
        chk({req, " irq empty R8"}, v, 32'(irq_ovf_e) << 26);
        rd(3'd3, v);
        chk({req, " irq data empty R8"}, v, 32'h0);
        chk({req, " levels empty"}, {30'h0, intx_level, msi_level}, 32'h0);
    endtask

    task automatic drain_err(input string req);
        logic [31:0] v;
        while (exp_err.size() > 0) begin
            rd(3'd4, v);
            chk({req, " err head"}, v, exp_err[0] | (32'(err_ovf_e) << 17));
            chk({req, " err_level"}, {31'h0, err_level}, 32'h1);
            wr(3'd4, 32'hFFFF_FFFF);
            void'(exp_err.pop_front());
        end
        rd(3'd4, v);
        chk({req, " err empty R8"}, v, 32'(err_ovf_e) << 17);
        chk({req, " err_level low"}, {31'h0, err_level}, 32'h0);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; msg_valid = 0; msg_kind = 0; msg_line = 0; msg_data = 0;
        msg_addr = 0; msg_reqid = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 5; i++) begin
            rd(3'(i), v);
            chk("R1 reset register", v, 32'h0);
        end
        chk("R1 reset levels", {29'h0, intx_level, msi_level, err_level}, 32'h0);

        // R11 base programming
        wr(3'd0, 32'h8000_1000);
        wr(3'd1, 32'h0000_0001);
        rd(3'd0, v); chk("R11 base low", v, 32'h8000_1000);
        rd(3'd1, v); chk("R11 base high", v, 32'h0000_0001);

        // R2 single INTx with level timing
        send_intx(2'd2);
        chk("R2 intx_level after arrival", {31'h0, intx_level}, 32'h1);
        drain_irq("R2");

        // R3 matching MSI
        send_msi(16'h0042, 64'h0000_0001_8000_1000);
        chk("R3 msi_level after arrival", {31'h0, msi_level}, 32'h1);
        drain_irq("R3");

        // R4 address mismatch in either half
        send_msi(16'h0011, 64'h0000_0001_8000_1004);
        send_msi(16'h0022, 64'h0000_0002_8000_1000);
        drain_irq("R4");

        // R7 interleaved order, all four INTx lines
        send_intx(2'd0);
        send_msi(16'h007F, 64'h0000_0001_8000_1000);
        send_intx(2'd1);
        send_intx(2'd3);
        send_msi(16'hABCD, 64'h0000_0001_8000_1000);
        send_intx(2'd2);
        drain_irq("R7");

        // R6 read and non-pop writes leave head in place
        send_intx(2'd1);
        rd(3'd2, v); chk("R6 first read", v, 32'h8800_0000);
        rd(3'd2, v); chk("R6 second read", v, 32'h8800_0000);
        wr(3'd2, 32'h1234_5678);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R6 after non-pop writes", v, 32'h8800_0000);
        drain_irq("R6");

        // R5 error entries
        send_err(16'hBEEF);
        chk("R5 err_level after arrival", {31'h0, err_level}, 32'h1);
        wr(3'd4, 32'h0000_0001);
        rd(3'd4, v); chk("R6 err non-pop write", v, 32'h0004_BEEF);
        send_err(16'h0001);
        drain_err("R5");

        // R9 pop on empty queues
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd2, 32'hFFFF_FFFF);
        send_err(16'h0101);
        send_intx(2'd3);
        drain_err("R9");
        drain_irq("R9");

        // R10 overflow of both queues
        for (int i = 0; i < 10; i++) begin
            if (i % 3 == 1) send_msi(16'(i), 64'h0000_0001_8000_1000);
            else send_intx(2'(i));
        end
        drain_irq("R10");
        for (int i = 0; i < 9; i++) send_err(16'(16'h0200 + i));
        drain_err("R10");
        rd(3'd2, v); chk("R10 irq ovf sticky", v, 32'h0400_0000);

        summary();
    end

endmodule